// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM built so that the data bus never needs an idle cycle when it changes direction. Each command (address, direction, byte-lane write enables) is captured on a rising clock edge. The data transfer for that command takes place in the clock cycle that follows, so a read can follow a write, or a write can follow a read, on consecutive cycles. The word is 18 bits wide and is built from two 9-bit lanes. The array depth is a parameter, so a shallow array can stand in for the full 256K-word part in simulation.

Read data is not registered on the way out. It comes combinationally from the array during the data cycle. The output enable is the only asynchronous control and can silence the bus at any moment. An internal 2-bit burst counter gives four beats from one loaded address, in either linear or interleaved order. An active-low clock enable freezes the whole block. Three chip enables of mixed polarity gate the start of new operations, and a data transfer that is already pending still completes.

The bidirectional bus is split into `d_in`, `d_out` and a drive flag `d_oe`. Surrounding logic or a pad ring turns these three signals into a tri-state pin.

Top module: `zbt_sram_model`

## Requirements
- R1: A read command accepted at an enabled edge drives `d_oe` high during the next cycle when `oe_n` is low. `d_out` carries the addressed word during that cycle.
- R2: Reads and writes alternate on consecutive commands with no idle cycle. A read issued on the edge that takes in the previous write's data returns the new data.
- R3: A write's data is taken from `d_in` at the enabled edge that ends its data cycle, with no extra latency.
- R4: `oe_n` high forces `d_oe` low at once, with no clock edge needed. Lowering it during a read data cycle restores the drive and the data at once, and internal state is not affected.
- R5: While `clk_en_n` is high, every synchronous input is ignored and all state is held. A read data cycle stays on the bus, and no write to the array occurs.
- R6: A new operation starts only when `adv_ld` is low with `sel_a_n` low, `sel_b` high and `sel_c_n` low. Any other chip-enable pattern with `adv_ld` low deselects, so `d_oe` is low in the next cycle. A write already pending still lands at that edge.
- R7: `d_oe` is low throughout the data cycle of every write, including each beat of a write burst.
- R8: `adv_ld` high steps a 2-bit beat counter, giving four beats per loaded address and returning to the first beat on the fifth. Each beat keeps the direction of the loaded command regardless of `rd_wr_n`. An advance while deselected stays deselected.
- R9: With `order_lin` = 1 at load, the beat-k address keeps the upper address bits. Its low two bits are (loaded low bits + k) mod 4.
- R10: With `order_lin` = 0 at load, the beat-k address keeps the upper bits. Its low two bits are the loaded low bits XOR k.
- R11: `lane_we_n[i]` low, sampled with the command or beat, lets a write update bits [9i+8:9i]. When high, that lane keeps its previous contents.
- R12: While `rst_n` is low, and after its synchronous release until the first command, `d_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write, sampled at load |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| order_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| lane_we_n | input | LANES | Per-lane active-low write enables |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| d_in | input | LANES*LANE_W | Write data for the current data cycle |
| d_out | output | LANES*LANE_W | Flow-through read data |
| d_oe | output | 1 | High when the model drives the data bus |

## Verification
The bench goes after turnaround cycles. A model that added a read register would return data one cycle late. A model that committed writes late would return stale data on a read issued right after a write. Burst sequences are read back in the other order from the one they were written in, and past the fourth beat. This exposes a wrong order formula, a counter that fails to wrap, or a beat that follows the live `rd_wr_n` pin instead of the loaded direction. Stalls, per-pin deselects, a write pending across a deselect, partial lane writes and an asynchronous `oe_n` change inside a cycle each catch a model that drops the pending transfer, writes the wrong lane or waits for a clock edge.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);

  typedef enum logic {
    ORD_ILV = 1'b0,
    ORD_LIN = 1'b1
  } burst_ord_e;
endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en_n,
  input  logic                sel_ok,
  input  logic                adv_ld,
  input  logic                rd_wr_n,
  input  logic                order_lin,
  input  logic [LANES-1:0]    lane_we_n,
  input  logic [ADDR_W-1:0]   addr,
  output logic                op_act,
  output logic                op_wr,
  output logic [ADDR_W-1:0]   base_q,
  output logic [BEAT_W-1:0]   beat_q,
  output burst_ord_e          ord_q,
  output logic [LANES-1:0]    be_n_q
);
  logic              act_d, wr_d;
  logic [ADDR_W-1:0] base_d;
  logic [BEAT_W-1:0] beat_d;
  burst_ord_e        ord_d;
  logic [LANES-1:0]  be_n_d;

  always_comb begin
    act_d  = op_act;
    wr_d   = op_wr;
    base_d = base_q;
    beat_d = beat_q;
    ord_d  = ord_q;
    be_n_d = be_n_q;
    if (!clk_en_n) begin
      be_n_d = lane_we_n;
      if (!adv_ld) begin
        if (sel_ok) begin
          act_d  = 1'b1;
          wr_d   = !rd_wr_n;
          base_d = addr;
          beat_d = '0;
          ord_d  = burst_ord_e'(order_lin);
        end else begin
          act_d  = 1'b0;
        end
      end else if (op_act) begin
        beat_d = beat_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_act <= 1'b0;
      op_wr  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      ord_q  <= ORD_LIN;
      be_n_q <= '1;
    end else begin
      op_act <= act_d;
      op_wr  <= wr_d;
      base_q <= base_d;
      beat_q <= beat_d;
      ord_q  <= ord_d;
      be_n_q <= be_n_d;
    end
  end

  // R5
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(op_act) && $stable(op_wr) && $stable(base_q) && $stable(beat_q)));

  // R6
  deselect_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !sel_ok) |=> !op_act);

  // R8
  burst_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && op_act) |=>
      (op_act && (op_wr == $past(op_wr)) && (beat_q == BEAT_W'($past(beat_q) + BEAT_W'(1)))));
endmodule

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  burst_ord_e        ord,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [BEAT_W-1:0] low;

  always_comb begin
    if (ord == ORD_LIN) low = base[BEAT_W-1:0] + beat;
    else                low = base[BEAT_W-1:0] ^ beat;
    eff_addr = {base[ADDR_W-1:BEAT_W], low};
  end
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_fire,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_fire && !lane_we_n[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/zbt_sram_model.sv
module zbt_sram_model
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    rd_wr_n,
  input  logic                    adv_ld,
  input  logic                    order_lin,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic              sel_ok;
  logic              op_act, op_wr, wr_fire;
  logic [ADDR_W-1:0] base_q, eff_addr;
  logic [BEAT_W-1:0] beat_q;
  burst_ord_e        ord_q;
  logic [LANES-1:0]  be_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_q_n), .clk_en_n(clk_en_n), .sel_ok(sel_ok),
    .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .order_lin(order_lin),
    .lane_we_n(lane_we_n), .addr(addr), .op_act(op_act), .op_wr(op_wr),
    .base_q(base_q), .beat_q(beat_q), .ord_q(ord_q), .be_n_q(be_n_q)
  );

  zbt_burst_addr #(.ADDR_W(ADDR_W)) agen_i (
    .base(base_q), .beat(beat_q), .ord(ord_q), .eff_addr(eff_addr)
  );

  assign wr_fire = !clk_en_n && op_act && op_wr;

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
    .clk(clk), .wr_fire(wr_fire), .lane_we_n(be_n_q), .addr(eff_addr),
    .wdata(d_in), .rdata(d_out)
  );

  assign d_oe = op_act && !op_wr && !oe_n;

  // R7
  write_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clk_en_n && !adv_ld && sel_ok && !rd_wr_n) |=> !d_oe);

  // R1
  read_drives_next_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clk_en_n && !adv_ld && sel_ok && rd_wr_n) |=> (d_oe || oe_n));
endmodule

// File: tb/zbt_sram_model_tb_top.sv
module zbt_sram_model_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, sel_a_n, sel_b, sel_c_n, rd_wr_n, adv_ld, order_lin, oe_n;
  logic [1:0]  lane_we_n;
  logic [7:0]  addr;
  logic [17:0] d_in, d_out;
  logic        d_oe;
  int          n_run = 0;
  int          n_fail = 0;
  logic [17:0] ref_mem [256];

  always #5 clk = ~clk;

  zbt_sram_model dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .rd_wr_n(rd_wr_n), .adv_ld(adv_ld), .order_lin(order_lin),
    .lane_we_n(lane_we_n), .addr(addr), .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  // row: req[55:52] cen_n adv sel rd be_n[1:0] lin addr[7:0] din[17:0] exp_oe exp_dout[17:0]
  localparam int NV = 11;
  localparam logic [55:0] VEC [NV] = '{
    {4'd7,  1'b0,1'b0,1'b1,1'b0,2'b00,1'b1,8'h10,18'h00000,1'b0,18'h00000}, // R7 write 0x10
    {4'd7,  1'b0,1'b0,1'b1,1'b0,2'b00,1'b1,8'h11,18'h2A5A5,1'b0,18'h00000}, // R7 write 0x11
    {4'd2,  1'b0,1'b0,1'b1,1'b1,2'b00,1'b1,8'h10,18'h11111,1'b1,18'h2A5A5}, // R2 read 0x10
    {4'd7,  1'b0,1'b0,1'b1,1'b0,2'b10,1'b1,8'h10,18'h00000,1'b0,18'h00000}, // R7 lane0 write
    {4'd2,  1'b0,1'b0,1'b1,1'b1,2'b00,1'b1,8'h11,18'h3FFFF,1'b1,18'h11111}, // R2 read 0x11
    {4'd11, 1'b0,1'b0,1'b1,1'b1,2'b00,1'b1,8'h10,18'h00000,1'b1,18'h2A5FF}, // R11 lane merge
    {4'd6,  1'b0,1'b0,1'b0,1'b1,2'b00,1'b1,8'h10,18'h00000,1'b0,18'h00000}, // R6 deselect
    {4'd5,  1'b1,1'b0,1'b1,1'b1,2'b00,1'b1,8'h11,18'h00000,1'b0,18'h00000}, // R5 stall
    {4'd1,  1'b0,1'b0,1'b1,1'b1,2'b00,1'b1,8'h11,18'h00000,1'b1,18'h11111}, // R1 read
    {4'd5,  1'b1,1'b0,1'b1,1'b0,2'b00,1'b1,8'h10,18'h3FFFF,1'b1,18'h11111}, // R5 stall holds
    {4'd3,  1'b0,1'b0,1'b1,1'b1,2'b00,1'b1,8'h10,18'h00000,1'b1,18'h2A5FF}  // R3 no stray write
  };

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cen, input logic adv, input logic an, input logic b,
                       input logic cn, input logic rd, input logic [1:0] be,
                       input logic lin, input logic [7:0] a, input logic [17:0] d);
    @(negedge clk);
    clk_en_n = cen; adv_ld = adv; sel_a_n = an; sel_b = b; sel_c_n = cn;
    rd_wr_n = rd; lane_we_n = be; order_lin = lin; addr = a; d_in = d;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] lin_a(input logic [7:0] a, input int k);
    return {a[7:2], 2'(a[1:0] + 2'(k))};
  endfunction

  function automatic logic [7:0] ilv_a(input logic [7:0] a, input int k);
    return {a[7:2], a[1:0] ^ 2'(k)};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    logic [17:0] dv;
    rst_n = 1'b0; clk_en_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    rd_wr_n = 1'b1; adv_ld = 1'b0; order_lin = 1'b1; lane_we_n = 2'b00;
    addr = '0; oe_n = 1'b0; d_in = '0;
    #17;
    chk("R12 in reset", {17'd0, d_oe}, 18'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) drive(0, 0, 1, 0, 1, 1, 2'b00, 1, 8'h00, 18'h0);
    chk("R12 after release", {17'd0, d_oe}, 18'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][51], VEC[i][50], !VEC[i][49], VEC[i][49], !VEC[i][49], VEC[i][48],
            VEC[i][47:46], VEC[i][45], VEC[i][44:37], VEC[i][36:19]);
      chk($sformatf("R%0d row %0d oe", VEC[i][55:52], i), {17'd0, d_oe}, {17'd0, VEC[i][18]});
      if (VEC[i][18]) chk($sformatf("R%0d row %0d data", VEC[i][55:52], i), d_out, VEC[i][17:0]);
    end

    // R9 linear write burst at 0x23, beats carry data on the following edges
    drive(0, 0, 0, 1, 0, 0, 2'b00, 1, 8'h23, 18'h0);
    chk("R7 burst write beat", {17'd0, d_oe}, 18'd0);
    for (int k = 0; k < 3; k++) begin
      dv = 18'h10A01 + 18'(k * 18'h01111);
      ref_mem[lin_a(8'h23, k)] = dv;
      drive(0, 1, 0, 1, 0, 1, 2'b00, 0, 8'hFF, dv);
      chk("R7 burst write beat", {17'd0, d_oe}, 18'd0);
    end
    dv = 18'h10A01 + 18'(3 * 18'h01111);
    ref_mem[lin_a(8'h23, 3)] = dv;
    // R10 interleaved read from 0x22, loaded on the edge that takes the last beat
    drive(0, 0, 0, 1, 0, 1, 2'b00, 0, 8'h22, dv);
    chk("R2 read after burst write", d_out, ref_mem[ilv_a(8'h22, 0)]);
    for (int k = 1; k <= 4; k++) begin
      drive(0, 1, 0, 1, 0, 0, 2'b11, 1, 8'h00, 18'h3FFFF);
      chk("R8 beat keeps read dir", {17'd0, d_oe}, 18'd1);
      chk(k == 4 ? "R8 wrap to first beat" : "R10 interleaved beat", d_out, ref_mem[ilv_a(8'h22, k)]);
    end
    // R9 linear read from 0x21
    drive(0, 0, 0, 1, 0, 1, 2'b00, 1, 8'h21, 18'h0);
    chk("R9 linear beat 0", d_out, ref_mem[lin_a(8'h21, 0)]);
    for (int k = 1; k < 4; k++) begin
      drive(0, 1, 0, 1, 0, 1, 2'b00, 0, 8'h00, 18'h0);
      chk("R9 linear beat", d_out, ref_mem[lin_a(8'h21, k)]);
    end

    // R4 asynchronous output enable
    @(negedge clk); oe_n = 1'b1;
    drive(0, 0, 0, 1, 0, 1, 2'b00, 1, 8'h20, 18'h0);
    chk("R4 oe_n high silences", {17'd0, d_oe}, 18'd0);
    #1 oe_n = 1'b0;
    #1 chk("R4 oe_n low drives", {17'd0, d_oe}, 18'd1);
    chk("R4 data after oe_n", d_out, ref_mem[8'h20]);

    // R6 each chip enable alone blocks a new operation
    for (int p = 0; p < 3; p++) begin
      drive(0, 0, 0, 1, 0, 1, 2'b00, 1, 8'h21, 18'h0);
      chk("R6 selected read", {17'd0, d_oe}, 18'd1);
      drive(0, 0, p == 0, p != 1, p == 2, 1, 2'b00, 1, 8'h22, 18'h0);
      chk("R6 single enable off", {17'd0, d_oe}, 18'd0);
    end
    drive(0, 1, 0, 1, 0, 1, 2'b00, 1, 8'h22, 18'h0);
    chk("R8 advance while idle", {17'd0, d_oe}, 18'd0);

    // R6 pending write completes across a deselect
    drive(0, 0, 0, 1, 0, 0, 2'b00, 1, 8'h30, 18'h0);
    drive(0, 0, 1, 1, 0, 1, 2'b00, 1, 8'h31, 18'h12345);
    chk("R6 deselect after write", {17'd0, d_oe}, 18'd0);
    drive(0, 0, 0, 1, 0, 1, 2'b00, 1, 8'h30, 18'h0);
    chk("R6 pending write landed", d_out, 18'h12345);
    chk("R1 read drive", {17'd0, d_oe}, 18'd1);

    report();
  end
endmodule